// File: doc/BRIEF.md
# Core Timer with Real-Time Interrupt

This block is a free-running prescaler counter for a small microcontroller. It has one 8-bit control and status register on a simple CPU bus with an address, a write strobe, write data and combinational read data. It keeps two sticky flags:

- an overflow flag, which is set each time the lowest eight counter stages wrap;
- a real-time flag, which is set on a tick taken from one of four selectable counter stages.

Each flag drives its own interrupt request through an enable bit. Software clears a flag by writing 1 to a separate write-only clear bit. The selected real-time tick is also brought out as a one-cycle pulse, which feeds an external watchdog. Changing the rate code therefore also changes the watchdog timeout.

The counter advances only on cycles where the count enable input is high. The four rate codes select periods of 2^(BASE_TAP+code) enabled cycles. By default, BASE_TAP is 14, so the periods run from 2^14 to 2^17 enabled cycles.

Top module: `core_tmr`

## Requirements
- R1: The register layout is bit 7 = overflow flag, bit 6 = real-time flag, bit 5 = overflow interrupt enable, bit 4 = real-time interrupt enable, bits 1:0 = rate code. The enables and the rate code read back as they were written.
- R2: After reset, the register reads 0x03 and all three outputs (both interrupt requests and the tick) are 0.
- R3: The overflow flag becomes 1 after the edge on which the low eight counter bits wrap from 0xFF to 0x00. After reset, this is the 256th enabled cycle and every 256th enabled cycle after it.
- R4: Each interrupt request is high exactly while its flag and its enable bit are both 1.
- R5: The write-only clear bits act on one flag each:
  - writing 1 to bit 3 clears the overflow flag;
  - writing 1 to bit 2 clears the real-time flag;
  - writing 0 to either bit, or clearing one flag, leaves the other flag unchanged.
- R6: Bits 3 and 2 always read as 0.
- R7: Write data on bits 7 and 6 has no effect on the flags.
- R8: The rate code selects the tick period: 00, 01, 10 and 11 give 2^(BASE_TAP), 2^(BASE_TAP+1), 2^(BASE_TAP+2) and 2^(BASE_TAP+3) enabled cycles. On each period boundary, the tick output is high for one cycle and the real-time flag sets at the same edge.
- R9: When a flag's set event and a write of 1 to its clear bit occur on the same edge, the flag ends up set.
- R10: The counter holds its value while the count enable is low. No tick and no flag event occurs during that time.
- R11: Reads of any address other than REG_ADDR return 0. Writes to other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count enable for the prescaler |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| rti_irq_o | output | 1 | Real-time interrupt request |
| rti_tick_o | output | 1 | One-cycle pulse per selected period, feeds the watchdog |

## Verification
Read data is combinational, so a register write is visible at the sample point right after its edge. A flag and the tick output both change one edge after the counter reaches the wrap value, so they appear together on the same sampled cycle. The bench samples a quarter period after each rising edge and keeps its own count of enabled edges. From that count it derives the cycle in which each tick and flag is due, and it checks the tick output on every cycle against that count. Writes are placed so that they do not fall on a period boundary, except in the deliberate same-edge set-and-clear case.

// File: rtl/core_tmr_pkg.sv
package core_tmr_pkg;
  localparam int NUM_RATES = 4;
  localparam int RATE_W    = 2;
  localparam int OVF_BITS  = 8;
  localparam int DATA_W    = 8;
  // bit positions in the control/status register
  localparam int B_OVF_FLAG = 7;
  localparam int B_RTI_FLAG = 6;
  localparam int B_OVF_EN   = 5;
  localparam int B_RTI_EN   = 4;
  localparam int B_OVF_CLR  = 3;
  localparam int B_RTI_CLR  = 2;
  localparam logic [RATE_W-1:0] RATE_RST = 2'b11;
endpackage

// File: rtl/core_tmr_cnt.sv
module core_tmr_cnt
  import core_tmr_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign ovf_evt_o = en_i & (&cnt_q[OVF_BITS-1:0]);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/core_tmr_tap.sv
module core_tmr_tap
  import core_tmr_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int BASE_TAP = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_evt_o,
  output logic              tick_o
);
  logic [NUM_RATES-1:0] wrap_vec;
  logic                 tick_q;

  // stage k wraps when all bits below it are ones on an enabled cycle
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
    assign wrap_vec[i] = en_i & (&cnt_i[BASE_TAP+i-1:0]);
  end

  assign tick_evt_o = wrap_vec[rate_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_evt_o;
  end

  assign tick_o = tick_q;

  a_r8_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  a_r10_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_q);
endmodule

// File: rtl/core_tmr_reg.sv
module core_tmr_reg
  import core_tmr_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_evt_i,
  input  logic              rti_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_irq_o,
  output logic              rti_irq_o,
  output logic [RATE_W-1:0] rate_o
);
  logic              hit, wr_hit;
  logic              ovf_q, rti_q, ovf_en_q, rti_en_q;
  logic [RATE_W-1:0] rate_q;
  logic              ovf_clr, rti_clr;

  assign hit     = (addr_i == REG_ADDR);
  assign wr_hit  = wr_i & hit;
  assign ovf_clr = wr_hit & wdata_i[B_OVF_CLR];
  assign rti_clr = wr_hit & wdata_i[B_RTI_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q    <= 1'b0;
      rti_q    <= 1'b0;
      ovf_en_q <= 1'b0;
      rti_en_q <= 1'b0;
      rate_q   <= RATE_RST;
    end else begin
      // set has priority over clear
      ovf_q <= ovf_evt_i | (ovf_q & ~ovf_clr);
      rti_q <= rti_evt_i | (rti_q & ~rti_clr);
      if (wr_hit) begin
        ovf_en_q <= wdata_i[B_OVF_EN];
        rti_en_q <= wdata_i[B_RTI_EN];
        rate_q   <= wdata_i[RATE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[B_OVF_FLAG]   = ovf_q;
      rdata_o[B_RTI_FLAG]   = rti_q;
      rdata_o[B_OVF_EN]     = ovf_en_q;
      rdata_o[B_RTI_EN]     = rti_en_q;
      rdata_o[RATE_W-1:0]   = rate_q;
    end
  end

  assign ovf_irq_o = ovf_q & ovf_en_q;
  assign rti_irq_o = rti_q & rti_en_q;
  assign rate_o    = rate_q;

  a_r3_ovf_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(ovf_evt_i));
  a_r9_ovf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);
  a_r9_rti_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_evt_i |=> rti_q);
  a_r5_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && wdata_i[B_OVF_CLR] && !ovf_evt_i) |=> !ovf_q);
  a_r5_rti_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && wdata_i[B_RTI_CLR] && !rti_evt_i) |=> !rti_q);
  a_r11_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || !hit) |=> $stable(rate_q) && $stable(ovf_en_q) && $stable(rti_en_q));
endmodule

// File: rtl/core_tmr.sv
module core_tmr
  import core_tmr_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h8,
  parameter int                BASE_TAP = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ovf_irq_o,
  output logic              rti_irq_o,
  output logic              rti_tick_o
);
  localparam int TOP_STAGE = BASE_TAP + NUM_RATES - 1;
  localparam int CNT_W     = (TOP_STAGE > OVF_BITS) ? TOP_STAGE : OVF_BITS;

  logic [CNT_W-1:0]  cnt;
  logic              ovf_evt, rti_evt;
  logic [RATE_W-1:0] rate;

  core_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .cnt_o     (cnt),
    .ovf_evt_o (ovf_evt)
  );

  core_tmr_tap #(.CNT_W(CNT_W), .BASE_TAP(BASE_TAP)) u_tap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cnt_en_i),
    .cnt_i      (cnt),
    .rate_i     (rate),
    .tick_evt_o (rti_evt),
    .tick_o     (rti_tick_o)
  );

  core_tmr_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .ovf_evt_i (ovf_evt),
    .rti_evt_i (rti_evt),
    .rdata_o   (rdata_o),
    .ovf_irq_o (ovf_irq_o),
    .rti_irq_o (rti_irq_o),
    .rate_o    (rate)
  );

  a_r8_tick_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_tick_o && addr_i == REG_ADDR) |-> rdata_o[B_RTI_FLAG]);
endmodule

// File: tb/core_tmr_tb.sv
module core_tmr_tb;
  localparam int          CLK_P    = 10;
  localparam int          ADDR_W   = 4;
  localparam logic [3:0]  REG_ADDR = 4'h8;
  localparam int          BASE_TAP = 4;
  localparam int          NVEC     = 7;
  // {write data, expected readback} with counting stopped
  localparam logic [15:0] VEC [NVEC] = '{
    16'hFF_33, 16'h00_00, 16'hC5_01, 16'h22_22, 16'h14_10, 16'h0B_03, 16'hEA_22
  };

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = REG_ADDR;
  logic [7:0] wdata = '0, rdata;
  logic ovf_irq, rti_irq, tick;
  int checks = 0, fails = 0;
  int ref_cnt = 0;
  int rate_m = 3;

  always #(CLK_P/2) clk = ~clk;

  core_tmr #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .BASE_TAP(BASE_TAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ovf_irq_o(ovf_irq), .rti_irq_o(rti_irq),
    .rti_tick_o(tick)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ref=%0d actual=0x%02h expected=0x%02h", req, ref_cnt, act, exp);
    end
  endtask

  // advance n edges, checking the tick output against the reference count (R8, R10)
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_P/4);
      if (cnt_en) ref_cnt++;
      chk("R8_R10 tick", {7'b0, tick},
          {7'b0, (cnt_en && (ref_cnt % (1 << (BASE_TAP + rate_m)) == 0))});
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    addr = REG_ADDR; wdata = d; wr = 1'b1;
    run(1);
    wr = 1'b0;
    rate_m = int'(d[1:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R2 reset read", rdata, 8'h03);
    chk("R2 reset outs", {5'b0, ovf_irq, rti_irq, tick}, 8'h00);
    rst_n = 1'b1;
    run(2);
    chk("R2 hold", rdata, 8'h03);

    // R11: other address
    addr = 4'h3;
    #1 chk("R11 read other", rdata, 8'h00);
    wdata = 8'hFF; wr = 1'b1;
    run(1);
    wr = 1'b0; addr = REG_ADDR;
    #1 chk("R11 write other", rdata, 8'h03);

    // R1 R6 R7 vectors
    for (int v = 0; v < NVEC; v++) begin
      do_wr(VEC[v][15:8]);
      chk("R1_R6_R7 vec", rdata, VEC[v][7:0]);
    end

    // R3 R4 overflow
    do_wr(8'h20);
    cnt_en = 1'b1;
    run(255);
    chk("R3 no ovf yet", {7'b0, rdata[7]}, 8'h00);
    chk("R4 ovf irq low", {7'b0, ovf_irq}, 8'h00);
    run(1);
    chk("R3 ovf set", rdata, 8'hE0);
    chk("R4 ovf irq", {7'b0, ovf_irq}, 8'h01);
    chk("R4 rti irq off", {7'b0, rti_irq}, 8'h00);

    // R5 clears
    do_wr(8'h20);
    chk("R5 zero no effect", rdata, 8'hE0);
    do_wr(8'h24);
    chk("R5 rti clr only", rdata, 8'hA0);
    do_wr(8'h28);
    chk("R5 ovf clr", rdata, 8'h20);
    chk("R5 ovf irq low", {7'b0, ovf_irq}, 8'h00);

    // R9 set wins at ref 512 (ovf and rti both due)
    run(511 - ref_cnt);
    do_wr(8'h2C);
    chk("R9 set wins", rdata, 8'hE0);

    // R8 rate 11
    do_wr(8'h1F);
    chk("R8 rate11 cleared", rdata, 8'h13);
    run(639 - ref_cnt);
    chk("R8 rate11 early", {7'b0, rti_irq}, 8'h00);
    run(1);
    chk("R8 rate11 flag", rdata, 8'h53);
    chk("R4 rti irq", {7'b0, rti_irq}, 8'h01);

    // R10 counting held
    cnt_en = 1'b0;
    run(300);
    chk("R10 held flags", rdata, 8'h53);
    cnt_en = 1'b1;
    do_wr(8'h17);
    run(767 - ref_cnt);
    chk("R10 no early", rdata, 8'h13);
    run(1);
    chk("R3_R8 at 768", rdata, 8'hD3);
    chk("R4 ovf irq masked", {7'b0, ovf_irq}, 8'h00);

    // R8 rate 01 and 10
    do_wr(8'h1D);
    run(799 - ref_cnt);
    chk("R8 rate01 early", {7'b0, rdata[6]}, 8'h00);
    run(1);
    chk("R8 rate01 flag", {7'b0, rdata[6]}, 8'h01);
    do_wr(8'h1E);
    run(831 - ref_cnt);
    chk("R8 rate10 early", {7'b0, rdata[6]}, 8'h00);
    run(1);
    chk("R8 rate10 flag", {7'b0, rdata[6]}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule